// File: doc/BRIEF.md
# Compressed Instruction Expander

This unit sits in a fetch or decode path and turns a fetched 32-bit word into a full 32-bit RV32 base-integer instruction. A word whose two low bits are 11 is already a full-length instruction and passes through untouched. Any other value marks a 16-bit compressed instruction in the low half. That half is decoded by quadrant and rebuilt into its I, S, B, U, J or R form.

The rebuild covers three things. The scrambled compressed immediates are reassembled into the standard immediate layouts. The 3-bit register fields are widened to name x8..x15. The reserved, special and ordinary encodings that share an opcode slot are separated. The Zcb byte and halfword memory forms, the extend and not forms, and the multiply form are also expanded. Encodings that are reserved or that belong to forms outside this scope raise an illegal flag, and in that case the instruction output is all zeros. The floating-point, 64-bit-only, push/pop and table-jump forms fall into this group. With the default parameter the result is registered, which gives one cycle of latency.

Top module: `rvc_expander`

## Requirements
- R1: After reset `insn_o` is 0 and `illegal_o` is 0. The result for a word on `word_i` appears on the outputs one clock edge later.
- R2: A word with bits [1:0] = 11 comes out unchanged on `insn_o`, and `illegal_o` is 0.
- R3: When `illegal_o` is 1, `insn_o` is all zeros. Bits [31:16] have no effect on a compressed word. A compressed word whose low 16 bits are all zero is illegal.
- R4: A 3-bit register field f names register 8+f. In quadrant 0, funct3 000 becomes addi rd', x2, u, where u = {b[10:7], b[12:11], b[5], b[6], 00}. If u = 0 the word is illegal.
- R5: Quadrant 0 funct3 010 becomes lw and funct3 110 becomes sw. Both use the base in b[9:7], the data register in b[4:2], and the offset {b[5], b[12:10], b[6], 00}.
- R6: In quadrant 1, funct3 000 becomes addi rd, rd, s and funct3 010 becomes addi rd, x0, s, where s = sext{b[12], b[6:2]}. Funct3 011 is illegal when b[12] = 0 and b[6:2] = 0. Otherwise, with rd = 2 it becomes addi x2, x2, sext{b[12], b[4:3], b[5], b[2], b[6], 0000}; with any other rd it becomes lui rd, sext{b[12], b[6:2]}.
- R7: In quadrant 1 funct3 100, b[11:10] selects the operation. 00 gives srli and 01 gives srai, each with shamt b[6:2]; b[12] = 1 in either case is illegal. 10 gives andi with s. 11 with b[12] = 0 gives sub, xor, or, and for b[6:5] = 00, 01, 10, 11. 11 with b[12] = 1 and b[6:5] = 00 or 01 is illegal.
- R8: Quadrant 1 funct3 101 becomes jal x0 and funct3 001 becomes jal x1. Both use sext{b[12], b[8], b[10:9], b[6], b[7], b[2], b[11], b[5:3], 0}. Funct3 110 becomes beq rs1', x0 and 111 becomes bne rs1', x0, with offset sext{b[12], b[6:5], b[2], b[11:10], b[4:3], 0}.
- R9: Quadrant 2 funct3 000 becomes slli rd, rd, b[6:2], and b[12] = 1 is illegal. Funct3 010 becomes lw rd, {b[3:2], b[12], b[6:4], 00}(x2), and rd = 0 is illegal. Funct3 110 becomes sw b[6:2], {b[8:7], b[12:9], 00}(x2).
- R10: Quadrant 2 funct3 100, with rd = b[11:7] and rs2 = b[6:2]. With b[12] = 0: rs2 = 0 gives jalr x0, 0(rd), and rd = 0 in that case is illegal; otherwise add rd, x0, rs2. With b[12] = 1: rd = rs2 = 0 gives ebreak (0x00100073); rs2 = 0 gives jalr x1, 0(rd); otherwise add rd, rd, rs2.
- R11: Quadrant 1 with b[15:10] = 100111 acts on rd' = b[9:7]. b[6:5] = 11 selects by b[4:2]: 000 gives andi rd', rd', 255; 001 gives sext.b; 010 gives zext.h (funct7 0000100, opcode 0110011); 011 gives sext.h; 101 gives xori rd', rd', -1. b[4:2] = 100, 110 and 111 are illegal. b[6:5] = 10 gives mul rd', rd', b[4:2]'.
- R12: Quadrant 0 funct3 100 selects by b[12:10]: 000 gives lbu with offset {b[5], b[6]}; 001 gives lhu when b[6] = 0 and lh when b[6] = 1, with offset {b[5], 0}; 010 gives sb with the byte offset; 011 with b[6] = 0 gives sh with the halfword offset. The base is b[9:7] and the data register is b[4:2].
- R13: These encodings are illegal: quadrant 0 funct3 001, 011, 101 and 111; quadrant 0 funct3 100 with b[12] = 1, or 011 with b[6] = 1; quadrant 2 funct3 001, 011, 101 and 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low reset, clears the output register |
| word_i | input | 32 | Fetched word; only bits [15:0] matter when bits [1:0] are not 11 |
| insn_o | output | 32 | Expanded 32-bit instruction, zero when illegal |
| illegal_o | output | 1 | High for reserved or unsupported compressed encodings |

## Verification
Several rules are checked on every cycle, across all inputs: a full-length word passes through, an illegal result is zeroed, an all-zero half-word is rejected, a branch reads its base register from the compressed field against x0, and the single ebreak encoding maps to its fixed value. Immediate reassembly, the reserved cases inside shared slots, and the Zcb forms are shown only by the bench's directed words. For those words the expected encodings are rebuilt from the field equations in the requirements.

// File: rtl/rvc_pkg.sv
package rvc_pkg;

    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_IMM   = 7'b0010011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;
    localparam logic [6:0] OPC_REG   = 7'b0110011;
    localparam logic [6:0] OPC_LUI   = 7'b0110111;
    localparam logic [6:0] OPC_BR    = 7'b1100011;
    localparam logic [6:0] OPC_JALR  = 7'b1100111;
    localparam logic [6:0] OPC_JAL   = 7'b1101111;
    localparam logic [31:0] INSN_BRK = 32'h0010_0073;

    typedef struct packed {
        logic [31:0] insn;
        logic        bad;
    } xlat_t;

    localparam xlat_t XLAT_BAD = '{insn: '0, bad: 1'b1};

    function automatic xlat_t good(input logic [31:0] insn);
        return '{insn: insn, bad: 1'b0};
    endfunction

    // compressed 3-bit register field names x8..x15
    function automatic logic [4:0] creg(input logic [2:0] f);
        return {2'b01, f};
    endfunction

    function automatic logic [31:0] fmt_i(input logic [11:0] imm, input logic [4:0] rs1,
                                          input logic [2:0] f3, input logic [4:0] rd,
                                          input logic [6:0] opc);
        return {imm, rs1, f3, rd, opc};
    endfunction

    function automatic logic [31:0] fmt_s(input logic [11:0] imm, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3,
                                          input logic [6:0] opc);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], opc};
    endfunction

    function automatic logic [31:0] fmt_r(input logic [6:0] f7, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3,
                                          input logic [4:0] rd, input logic [6:0] opc);
        return {f7, rs2, rs1, f3, rd, opc};
    endfunction

    function automatic logic [31:0] fmt_b(input logic [12:1] ofs, input logic [4:0] rs1,
                                          input logic [2:0] f3);
        return {ofs[12], ofs[10:5], 5'd0, rs1, f3, ofs[4:1], ofs[11], OPC_BR};
    endfunction

    function automatic logic [31:0] fmt_j(input logic [20:1] ofs, input logic [4:0] rd);
        return {ofs[20], ofs[10:1], ofs[11], ofs[19:12], rd, OPC_JAL};
    endfunction

endpackage

// File: rtl/rvc_quad0.sv
module rvc_quad0
    import rvc_pkg::*;
(
    input  logic [15:2] hw_i,
    output xlat_t       res_o
);
    logic [4:0]  rb;
    logic [4:0]  rv;
    logic [9:0]  sp_ofs;
    logic [6:0]  w_ofs;
    logic [11:0] b_ofs;
    logic [11:0] h_ofs;

    always_comb begin
        rb     = creg(hw_i[9:7]);
        rv     = creg(hw_i[4:2]);
        sp_ofs = {hw_i[10:7], hw_i[12:11], hw_i[5], hw_i[6], 2'b00};
        w_ofs  = {hw_i[5], hw_i[12:10], hw_i[6], 2'b00};
        b_ofs  = {10'd0, hw_i[5], hw_i[6]};
        h_ofs  = {10'd0, hw_i[5], 1'b0};
        res_o  = XLAT_BAD;
        unique case (hw_i[15:13])
            3'b000: if (sp_ofs != '0) res_o = good(fmt_i({2'b00, sp_ofs}, 5'd2, 3'b000, rv, OPC_IMM));
            3'b010: res_o = good(fmt_i({5'd0, w_ofs}, rb, 3'b010, rv, OPC_LOAD));
            3'b110: res_o = good(fmt_s({5'd0, w_ofs}, rv, rb, 3'b010, OPC_STORE));
            3'b100: begin
                unique case (hw_i[12:10])
                    3'b000: res_o = good(fmt_i(b_ofs, rb, 3'b100, rv, OPC_LOAD));
                    3'b001: res_o = good(fmt_i(h_ofs, rb, hw_i[6] ? 3'b001 : 3'b101, rv, OPC_LOAD));
                    3'b010: res_o = good(fmt_s(b_ofs, rv, rb, 3'b000, OPC_STORE));
                    3'b011: if (!hw_i[6]) res_o = good(fmt_s(h_ofs, rv, rb, 3'b001, OPC_STORE));
                    default: res_o = XLAT_BAD;
                endcase
            end
            default: res_o = XLAT_BAD;
        endcase
    end
endmodule

// File: rtl/rvc_quad1.sv
module rvc_quad1
    import rvc_pkg::*;
(
    input  logic [15:2] hw_i,
    output xlat_t       res_o
);
    logic [4:0]  rd;
    logic [4:0]  rdc;
    logic [4:0]  rsc;
    logic [11:0] simm;
    logic [11:0] sp16;
    logic [19:0] uimm;
    logic [20:1] jofs;
    logic [12:1] bofs;
    logic [2:0]  alu_f3;

    always_comb begin
        rd   = hw_i[11:7];
        rdc  = creg(hw_i[9:7]);
        rsc  = creg(hw_i[4:2]);
        simm = {{6{hw_i[12]}}, hw_i[12], hw_i[6:2]};
        sp16 = {{2{hw_i[12]}}, hw_i[12], hw_i[4:3], hw_i[5], hw_i[2], hw_i[6], 4'b0000};
        uimm = {{14{hw_i[12]}}, hw_i[12], hw_i[6:2]};
        jofs = {{9{hw_i[12]}}, hw_i[12], hw_i[8], hw_i[10:9], hw_i[6], hw_i[7], hw_i[2],
                hw_i[11], hw_i[5:3]};
        bofs = {{4{hw_i[12]}}, hw_i[12], hw_i[6:5], hw_i[2], hw_i[11:10], hw_i[4:3]};
        unique case (hw_i[6:5])
            2'b00:   alu_f3 = 3'b000;
            2'b01:   alu_f3 = 3'b100;
            2'b10:   alu_f3 = 3'b110;
            default: alu_f3 = 3'b111;
        endcase
        res_o = XLAT_BAD;
        unique case (hw_i[15:13])
            3'b000: res_o = good(fmt_i(simm, rd, 3'b000, rd, OPC_IMM));
            3'b001: res_o = good(fmt_j(jofs, 5'd1));
            3'b010: res_o = good(fmt_i(simm, 5'd0, 3'b000, rd, OPC_IMM));
            3'b011: begin
                if (!hw_i[12] && hw_i[6:2] == 5'd0) res_o = XLAT_BAD;
                else if (rd == 5'd2)              res_o = good(fmt_i(sp16, 5'd2, 3'b000, 5'd2, OPC_IMM));
                else                              res_o = good({uimm, rd, OPC_LUI});
            end
            3'b100: begin
                unique case (hw_i[11:10])
                    2'b00, 2'b01: begin
                        if (!hw_i[12])
                            res_o = good(fmt_r({1'b0, hw_i[10], 5'd0}, hw_i[6:2], rdc, 3'b101, rdc, OPC_IMM));
                    end
                    2'b10: res_o = good(fmt_i(simm, rdc, 3'b111, rdc, OPC_IMM));
                    default: begin
                        if (!hw_i[12]) begin
                            res_o = good(fmt_r(hw_i[6:5] == 2'b00 ? 7'h20 : 7'h00, rsc, rdc, alu_f3, rdc, OPC_REG));
                        end else if (hw_i[6:5] == 2'b10) begin
                            res_o = good(fmt_r(7'h01, rsc, rdc, 3'b000, rdc, OPC_REG));
                        end else if (hw_i[6:5] == 2'b11) begin
                            unique case (hw_i[4:2])
                                3'b000:  res_o = good(fmt_i(12'd255, rdc, 3'b111, rdc, OPC_IMM));
                                3'b001:  res_o = good(fmt_r(7'h30, 5'd4, rdc, 3'b001, rdc, OPC_IMM));
                                3'b010:  res_o = good(fmt_r(7'h04, 5'd0, rdc, 3'b100, rdc, OPC_REG));
                                3'b011:  res_o = good(fmt_r(7'h30, 5'd5, rdc, 3'b001, rdc, OPC_IMM));
                                3'b101:  res_o = good(fmt_i(12'hFFF, rdc, 3'b100, rdc, OPC_IMM));
                                default: res_o = XLAT_BAD;
                            endcase
                        end
                    end
                endcase
            end
            3'b101:  res_o = good(fmt_j(jofs, 5'd0));
            default: res_o = good(fmt_b(bofs, rdc, {2'b00, hw_i[13]}));
        endcase
    end
endmodule

// File: rtl/rvc_quad2.sv
module rvc_quad2
    import rvc_pkg::*;
(
    input  logic [15:2] hw_i,
    output xlat_t       res_o
);
    logic [4:0]  rd;
    logic [4:0]  rs2;
    logic [11:0] ld_ofs;
    logic [11:0] st_ofs;

    always_comb begin
        rd     = hw_i[11:7];
        rs2    = hw_i[6:2];
        ld_ofs = {4'd0, hw_i[3:2], hw_i[12], hw_i[6:4], 2'b00};
        st_ofs = {4'd0, hw_i[8:7], hw_i[12:9], 2'b00};
        res_o  = XLAT_BAD;
        unique case (hw_i[15:13])
            3'b000: if (!hw_i[12]) res_o = good(fmt_r(7'h00, rs2, rd, 3'b001, rd, OPC_IMM));
            3'b010: if (rd != 5'd0) res_o = good(fmt_i(ld_ofs, 5'd2, 3'b010, rd, OPC_LOAD));
            3'b110: res_o = good(fmt_s(st_ofs, rs2, 5'd2, 3'b010, OPC_STORE));
            3'b100: begin
                if (!hw_i[12]) begin
                    if (rs2 != 5'd0)     res_o = good(fmt_r(7'h00, rs2, 5'd0, 3'b000, rd, OPC_REG));
                    else if (rd != 5'd0) res_o = good(fmt_i(12'd0, rd, 3'b000, 5'd0, OPC_JALR));
                end else begin
                    if (rs2 != 5'd0)     res_o = good(fmt_r(7'h00, rs2, rd, 3'b000, rd, OPC_REG));
                    else if (rd != 5'd0) res_o = good(fmt_i(12'd0, rd, 3'b000, 5'd1, OPC_JALR));
                    else                 res_o = good(INSN_BRK);
                end
            end
            default: res_o = XLAT_BAD;
        endcase
    end
endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
    import rvc_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [31:0] word_i,
    output logic [31:0] insn_o,
    output logic        illegal_o
);
    xlat_t res_q0;
    xlat_t res_q1;
    xlat_t res_q2;
    xlat_t out_d;
    xlat_t out_q;

    rvc_quad0 i_quad0 (.hw_i(word_i[15:2]), .res_o(res_q0));
    rvc_quad1 i_quad1 (.hw_i(word_i[15:2]), .res_o(res_q1));
    rvc_quad2 i_quad2 (.hw_i(word_i[15:2]), .res_o(res_q2));

    always_comb begin
        unique case (word_i[1:0])
            2'b00:   out_d = res_q0;
            2'b01:   out_d = res_q1;
            2'b10:   out_d = res_q2;
            default: out_d = good(word_i);
        endcase
        if (out_d.bad) out_d.insn = '0;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) out_q <= '{insn: '0, bad: 1'b0};
                else         out_q <= out_d;
            end

            a_r2_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (word_i[1:0] == 2'b11) |=> (insn_o == $past(word_i) && !illegal_o));

            a_r3_bad_is_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
                illegal_o |-> (insn_o == 32'd0));

            a_r3_zero_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (word_i[15:0] == 16'd0) |=> illegal_o);

            a_r2_full_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (!illegal_o && $past(rst_ni)) |-> (insn_o[1:0] == 2'b11));

            a_r8_branch_x0: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (word_i[1:0] == 2'b01 && word_i[15:14] == 2'b11) |=>
                (insn_o[6:0] == OPC_BR && insn_o[24:20] == 5'd0 &&
                 insn_o[19:15] == {2'b01, $past(word_i[9:7])}));

            a_r10_ebreak: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (word_i[15:0] == 16'h9002) |=> (insn_o == INSN_BRK && !illegal_o));
        end else begin : g_comb
            assign out_q = out_d;
        end
    endgenerate

    assign insn_o    = out_q.insn;
    assign illegal_o = out_q.bad;
endmodule

// File: tb/test_rvc_expander.sv
`timescale 1ns/1ps
module test_rvc_expander;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] word_i = 32'd0;
    logic [31:0] insn_o;
    logic        illegal_o;

    always #2.5 clk = ~clk;

    rvc_expander i_rvc_expander (
        .clk_i(clk), .rst_ni(rst_n), .word_i(word_i),
        .insn_o(insn_o), .illegal_o(illegal_o)
    );

    typedef struct {
        logic [31:0] w;
        logic [31:0] e;
        logic        b;
        string       tag;
        int          st;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // reference encoders for the standard 32-bit formats
    function automatic logic [31:0] ei(input logic [31:0] imm, input logic [4:0] rs1,
                                       input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
        return {imm[11:0], rs1, f3, rd, op};
    endfunction
    function automatic logic [31:0] es(input logic [31:0] imm, input logic [4:0] rs2,
                                       input logic [4:0] rs1, input logic [2:0] f3, input logic [6:0] op);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
    endfunction
    function automatic logic [31:0] eb(input logic [31:0] imm, input logic [4:0] rs1, input logic [2:0] f3);
        return {imm[12], imm[10:5], 5'd0, rs1, f3, imm[4:1], imm[11], 7'h63};
    endfunction
    function automatic logic [31:0] ej(input logic [31:0] imm, input logic [4:0] rd);
        return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'h6f};
    endfunction
    function automatic logic [31:0] er(input logic [6:0] f7, input logic [4:0] rs2, input logic [4:0] rs1,
                                       input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
        return {f7, rs2, rs1, f3, rd, op};
    endfunction

    task automatic put(input logic [31:0] w, input logic [31:0] e, input logic b, input string tag);
        @(negedge clk);
        word_i = w;
        q.push_back('{w: w, e: e, b: b, tag: tag, st: cyc});
    endtask
    task automatic cgood(input logic [15:0] hw, input logic [31:0] e, input string tag);
        put({16'h5A5A, hw}, e, 1'b0, tag);
    endtask
    task automatic cbad(input logic [15:0] hw, input string tag);
        put({16'hA5C3, hw}, 32'd0, 1'b1, tag);
    endtask

    // monitor: results appear one edge after the word is driven
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].st < cyc) begin
            item_t it;
            it = q.pop_front();
            n_run++;
            if (insn_o !== it.e || illegal_o !== it.b) begin
                n_fail++;
                $display("FAIL %s word=%h: got insn=%h bad=%b, expected insn=%h bad=%b",
                         it.tag, it.w, insn_o, illegal_o, it.e, it.b);
            end
        end
    end

    initial begin
        word_i = 32'h00A5_8593;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_run++;
        if (insn_o !== 32'd0 || illegal_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: got insn=%h bad=%b, expected insn=00000000 bad=0", insn_o, illegal_o);
        end
        rst_n = 1'b1;

        // R1 R2 full-length word passes
        put(32'h00A5_8593, 32'h00A5_8593, 1'b0, "R1 R2 passthrough");
        put(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R2 passthrough ones");
        // R3 all-zero half-word, upper half ignored
        put(32'h0000_0000, 32'd0, 1'b1, "R3 zero word");
        cbad(16'h0000, "R3 zero half with upper bits");
        // R4 sp-relative add
        cgood({3'b000, 2'b01, 4'b1010, 1'b1, 1'b0, 3'b010, 2'b00}, ei(660, 5'd2, 3'b000, 5'd10, 7'h13), "R4 addi4spn");
        cbad({3'b000, 8'd0, 3'b001, 2'b00}, "R4 addi4spn zero imm");
        // R5 word load/store
        cgood({3'b010, 3'b011, 3'b001, 1'b0, 1'b1, 3'b111, 2'b00}, ei(88, 5'd9, 3'b010, 5'd15, 7'h03), "R5 lw");
        cgood({3'b110, 3'b100, 3'b000, 1'b1, 1'b0, 3'b101, 2'b00}, es(36, 5'd13, 5'd8, 3'b010, 7'h23), "R5 sw");
        // R6 immediates
        cgood({3'b000, 1'b1, 5'd7, 5'b11101, 2'b01}, ei(-3, 5'd7, 3'b000, 5'd7, 7'h13), "R6 addi");
        cgood({3'b010, 1'b0, 5'd12, 5'b00101, 2'b01}, ei(5, 5'd0, 3'b000, 5'd12, 7'h13), "R6 li");
        cgood({3'b011, 1'b1, 5'd3, 5'b11110, 2'b01}, {20'hFFFFE, 5'd3, 7'h37}, "R6 lui");
        cgood({3'b011, 1'b1, 5'd2, 5'b01100, 2'b01}, ei(-192, 5'd2, 3'b000, 5'd2, 7'h13), "R6 addi16sp");
        cbad({3'b011, 1'b0, 5'd5, 5'd0, 2'b01}, "R6 lui zero");
        cbad({3'b011, 1'b0, 5'd2, 5'd0, 2'b01}, "R6 addi16sp zero");
        // R7 arithmetic group
        cgood({3'b100, 1'b0, 2'b00, 3'b011, 5'd7, 2'b01}, er(7'h00, 5'd7, 5'd11, 3'b101, 5'd11, 7'h13), "R7 srli");
        cgood({3'b100, 1'b0, 2'b01, 3'b000, 5'd31, 2'b01}, er(7'h20, 5'd31, 5'd8, 3'b101, 5'd8, 7'h13), "R7 srai");
        cbad({3'b100, 1'b1, 2'b00, 3'b000, 5'd1, 2'b01}, "R7 srli wide shamt");
        cgood({3'b100, 1'b1, 2'b10, 3'b110, 5'b10000, 2'b01}, ei(-16, 5'd14, 3'b111, 5'd14, 7'h13), "R7 andi");
        cgood({3'b100, 1'b0, 2'b11, 3'b001, 2'b00, 3'b010, 2'b01}, er(7'h20, 5'd10, 5'd9, 3'b000, 5'd9, 7'h33), "R7 sub");
        cgood({3'b100, 1'b0, 2'b11, 3'b001, 2'b01, 3'b010, 2'b01}, er(7'h00, 5'd10, 5'd9, 3'b100, 5'd9, 7'h33), "R7 xor");
        cgood({3'b100, 1'b0, 2'b11, 3'b001, 2'b10, 3'b010, 2'b01}, er(7'h00, 5'd10, 5'd9, 3'b110, 5'd9, 7'h33), "R7 or");
        cgood({3'b100, 1'b0, 2'b11, 3'b111, 2'b11, 3'b000, 2'b01}, er(7'h00, 5'd8, 5'd15, 3'b111, 5'd15, 7'h33), "R7 and");
        cbad({3'b100, 1'b1, 2'b11, 3'b001, 2'b00, 3'b010, 2'b01}, "R7 word-sub slot");
        // R8 jumps and branches
        cgood({3'b101, 11'h7FF, 2'b01}, ej(-2, 5'd0), "R8 j back");
        cgood({3'b001, 11'b00000010101, 2'b01}, ej(164, 5'd1), "R8 jal fwd");
        cgood({3'b110, 11'b11110011011, 2'b01}, eb(-6, 5'd12, 3'b000), "R8 beq");
        cgood({3'b111, 11'b00001100011, 2'b01}, eb(34, 5'd11, 3'b001), "R8 bne");
        // R9 quadrant 2 sp and shift
        cgood({3'b000, 1'b0, 5'd20, 5'd3, 2'b10}, er(7'h00, 5'd3, 5'd20, 3'b001, 5'd20, 7'h13), "R9 slli");
        cbad({3'b000, 1'b1, 5'd20, 5'd3, 2'b10}, "R9 slli wide shamt");
        cgood({3'b010, 1'b1, 5'd9, 5'b01011, 2'b10}, ei(232, 5'd2, 3'b010, 5'd9, 7'h03), "R9 lwsp");
        cbad({3'b010, 1'b0, 5'd0, 5'd4, 2'b10}, "R9 lwsp rd0");
        cgood({3'b110, 6'b011010, 5'd17, 2'b10}, es(152, 5'd17, 5'd2, 3'b010, 7'h23), "R9 swsp");
        // R10 jump/move/add slot
        cgood({3'b100, 1'b0, 5'd5, 5'd6, 2'b10}, er(7'h00, 5'd6, 5'd0, 3'b000, 5'd5, 7'h33), "R10 mv");
        cgood({3'b100, 1'b0, 5'd1, 5'd0, 2'b10}, ei(0, 5'd1, 3'b000, 5'd0, 7'h67), "R10 jr");
        cbad({3'b100, 1'b0, 5'd0, 5'd0, 2'b10}, "R10 jr x0");
        cgood(16'h9002, 32'h0010_0073, "R10 ebreak");
        cgood({3'b100, 1'b1, 5'd7, 5'd0, 2'b10}, ei(0, 5'd7, 3'b000, 5'd1, 7'h67), "R10 jalr");
        cgood({3'b100, 1'b1, 5'd8, 5'd9, 2'b10}, er(7'h00, 5'd9, 5'd8, 3'b000, 5'd8, 7'h33), "R10 add");
        // R11 extend / not / mul
        cgood({6'b100111, 3'b010, 2'b11, 3'b000, 2'b01}, ei(255, 5'd10, 3'b111, 5'd10, 7'h13), "R11 zext.b");
        cgood({6'b100111, 3'b010, 2'b11, 3'b001, 2'b01}, er(7'h30, 5'd4, 5'd10, 3'b001, 5'd10, 7'h13), "R11 sext.b");
        cgood({6'b100111, 3'b010, 2'b11, 3'b010, 2'b01}, er(7'h04, 5'd0, 5'd10, 3'b100, 5'd10, 7'h33), "R11 zext.h");
        cgood({6'b100111, 3'b010, 2'b11, 3'b011, 2'b01}, er(7'h30, 5'd5, 5'd10, 3'b001, 5'd10, 7'h13), "R11 sext.h");
        cgood({6'b100111, 3'b010, 2'b11, 3'b101, 2'b01}, ei(-1, 5'd10, 3'b100, 5'd10, 7'h13), "R11 not");
        cbad({6'b100111, 3'b010, 2'b11, 3'b100, 2'b01}, "R11 zext.w");
        cgood({6'b100111, 3'b001, 2'b10, 3'b011, 2'b01}, er(7'h01, 5'd11, 5'd9, 3'b000, 5'd9, 7'h33), "R11 mul");
        // R12 byte/half memory
        cgood({6'b100000, 3'b001, 1'b1, 1'b1, 3'b010, 2'b00}, ei(3, 5'd9, 3'b100, 5'd10, 7'h03), "R12 lbu");
        cgood({6'b100001, 3'b000, 1'b0, 1'b1, 3'b111, 2'b00}, ei(2, 5'd8, 3'b101, 5'd15, 7'h03), "R12 lhu");
        cgood({6'b100001, 3'b000, 1'b1, 1'b0, 3'b111, 2'b00}, ei(0, 5'd8, 3'b001, 5'd15, 7'h03), "R12 lh");
        cgood({6'b100010, 3'b011, 1'b0, 1'b1, 3'b100, 2'b00}, es(2, 5'd12, 5'd11, 3'b000, 7'h23), "R12 sb");
        cgood({6'b100011, 3'b011, 1'b0, 1'b1, 3'b100, 2'b00}, es(2, 5'd12, 5'd11, 3'b001, 7'h23), "R12 sh");
        // R13 out-of-scope slots
        cbad({6'b100011, 3'b011, 1'b1, 1'b1, 3'b100, 2'b00}, "R13 sh b6 set");
        cbad({3'b001, 3'b010, 3'b001, 2'b00, 3'b010, 2'b00}, "R13 q0 fp load");
        cbad({3'b111, 3'b010, 3'b001, 2'b00, 3'b010, 2'b00}, "R13 q0 f3 111");
        cbad({6'b100100, 3'b001, 2'b00, 3'b010, 2'b00}, "R13 q0 f6 1001xx");
        cbad({3'b101, 5'b11000, 4'd4, 2'd0, 2'b10}, "R13 q2 push");
        cbad({3'b011, 1'b0, 5'd3, 5'd4, 2'b10}, "R13 q2 f3 011");

        repeat (4) @(negedge clk);
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R1 latency: %0d results never compared, expected 0", q.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule